// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status and Priority Register

This block performs one arithmetic or logic operation per accepted cycle on two operands. The operands are either a full data word (16 bits by default) or a byte taken from their low halves. The result is registered. Alongside it, a status register is updated with five condition flags: carry, half carry, signed overflow, negative and zero. Add and subtract each have a plain form and a carry-chained form. The chained forms leave the zero flag set only when every word of a multi-word sum or difference was zero, so software can test a wide result after its last chained operation.

The same status register holds a 3-bit processor priority field. An external high-order priority bit is prepended to this field to form a 4-bit processor level. A lock input makes the field read-only. The block also signals when the current level masks ordinary interrupt sources. It does not arbitrate between interrupts.

Top module: `alu_status_unit`

## Requirements
- R1: Operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 inclusive OR, 6 exclusive OR, 7 move operand A. Add-with-carry computes A+B+carry_in. Subtract-with-borrow computes A-B-(1-carry_in). The result is taken modulo the operand width and appears on `result` one clock after `op_valid`.
- R2: For arithmetic operations, flag_c is the carry out of the operand MSB (bit 7 in byte mode, bit 15 in word mode). For subtraction, flag_c=1 means no borrow occurred.
- R3: For arithmetic operations, flag_dc is the carry out of bit 3 in byte mode and out of bit 7 in word mode. For subtraction it is 1 when no borrow came out of that bit.
- R4: For arithmetic operations, flag_ov is set when the two's-complement result, read at the operand width, falls outside the signed range.
- R5: flag_n equals the result MSB at the operand width. For operation codes 0, 2 and 4 to 7, flag_z is set exactly when the result is zero.
- R6: For operation codes 1 and 3, flag_z is cleared on a nonzero result and is otherwise left unchanged. It is never set by these operations.
- R7: Logic operations (codes 4 to 7) update only flag_n and flag_z. flag_c, flag_dc and flag_ov keep their values.
- R8: In byte mode, only operand bits 7:0 take part, and result bits 15:8 are zero.
- R9: While op_valid is low, result and all five flags hold their values.
- R10: When ipl_wr_en is high and ipl_lock is low, ipl_field takes ipl_wr_data on the next clock. When ipl_lock is high, a write is ignored.
- R11: cpu_level is {ipl_hi, ipl_field}. user_irq_masked is high when ipl_hi is 1 or ipl_field is 7.
- R12: A synchronous, active-high rst clears result, all flags and ipl_field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the operation this cycle |
| op_code | input | 3 | Operation select (see R1) |
| byte_mode | input | 1 | 1 = byte operands, 0 = word operands |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B |
| carry_in | input | 1 | Carry/not-borrow for chained operations |
| ipl_wr_en | input | 1 | Write request for the priority field |
| ipl_wr_data | input | IPL_W | New priority field value |
| ipl_lock | input | 1 | Makes the priority field read-only |
| ipl_hi | input | 1 | External high-order priority bit |
| result | output | DATA_W | Registered result |
| flag_c | output | 1 | Carry / not-borrow |
| flag_dc | output | 1 | Half carry |
| flag_ov | output | 1 | Signed overflow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| ipl_field | output | IPL_W | Stored priority field |
| cpu_level | output | IPL_W+1 | Combined processor priority level |
| user_irq_masked | output | 1 | Ordinary interrupts masked |

## Verification
In byte mode, the four arithmetic operations are swept over a dense grid of operand pairs with alternating carry input. This grid crosses every carry, half-carry and sign boundary, so it separates carry from overflow and carry-out from the wrong bit position. In word mode, a set of corner operands (0, 1, 0x7FFF, 0x8000, 0xFFFF and mixed patterns) is crossed with both carry values, followed by pseudo-random pairs. These show whether the half-carry moved from bit 3 to bit 7 and whether the flags are taken at bit 15. Chained sequences show whether the zero flag is ever set by a chained operation or is written directly. Logic operations placed between arithmetic ones show whether the arithmetic flags are preserved. All sixteen priority combinations are written with and without the lock.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_AND  = 3'd4,
    OP_IOR  = 3'd5,
    OP_XOR  = 3'd6,
    OP_MOVA = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic ov;
    logic n;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  input  logic              byte_mode,
  input  logic              carry_in,
  input  logic              z_prev,
  output logic [DATA_W-1:0] res,
  output alu_flags_t        flags
);

  localparam int HALF_W = DATA_W / 2;
  localparam int NIB_W  = HALF_W / 2;

  logic              is_sub;
  logic              chained;
  logic              cin;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;
  logic              cy_half;
  logic              cy_nib;
  logic              a_msb, b_msb, r_msb;

  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_SUBB);
    chained = (op == OP_ADDC) || (op == OP_SUBB);
    b_eff   = is_sub ? ~opb : opb;
    cin     = chained ? carry_in : is_sub;
    sum_w   = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    // carry into a bit position, recovered from the sum bit
    cy_half = sum_w[HALF_W] ^ opa[HALF_W] ^ b_eff[HALF_W];
    cy_nib  = sum_w[NIB_W]  ^ opa[NIB_W]  ^ b_eff[NIB_W];

    if (byte_mode) begin
      res      = {{HALF_W{1'b0}}, sum_w[HALF_W-1:0]};
      flags.c  = cy_half;
      flags.dc = cy_nib;
      a_msb    = opa[HALF_W-1];
      b_msb    = b_eff[HALF_W-1];
      r_msb    = sum_w[HALF_W-1];
    end else begin
      res      = sum_w[DATA_W-1:0];
      flags.c  = sum_w[DATA_W];
      flags.dc = cy_half;
      a_msb    = opa[DATA_W-1];
      b_msb    = b_eff[DATA_W-1];
      r_msb    = sum_w[DATA_W-1];
    end

    flags.ov = (a_msb == b_msb) && (r_msb != a_msb);
    flags.n  = r_msb;
    flags.z  = chained ? (z_prev && (res == '0)) : (res == '0);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_e           op,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] res,
  output logic              n,
  output logic              z
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] raw;

  always_comb begin
    case (op)
      OP_AND:  raw = opa & opb;
      OP_IOR:  raw = opa | opb;
      OP_XOR:  raw = opa ^ opb;
      default: raw = opa;
    endcase
    res = byte_mode ? {{HALF_W{1'b0}}, raw[HALF_W-1:0]} : raw;
    n   = byte_mode ? raw[HALF_W-1] : raw[DATA_W-1];
    z   = (res == '0);
  end

endmodule

// File: rtl/alu_stat_reg.sv
module alu_stat_reg
  import alu_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_all,
  input  logic             upd_nz,
  input  alu_flags_t       flags_d,
  input  logic             ipl_wr_en,
  input  logic [IPL_W-1:0] ipl_wr_data,
  input  logic             ipl_lock,
  output alu_flags_t       flags_q,
  output logic [IPL_W-1:0] ipl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (upd_all) begin
      flags_q <= flags_d;
    end else if (upd_nz) begin
      flags_q.n <= flags_d.n;
      flags_q.z <= flags_d.z;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_q <= '0;
    end else if (ipl_wr_en && !ipl_lock) begin
      ipl_q <= ipl_wr_data;
    end
  end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  input  logic              ipl_wr_en,
  input  logic [IPL_W-1:0]  ipl_wr_data,
  input  logic              ipl_lock,
  input  logic              ipl_hi,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_dc,
  output logic              flag_ov,
  output logic              flag_n,
  output logic              flag_z,
  output logic [IPL_W-1:0]  ipl_field,
  output logic [IPL_W:0]    cpu_level,
  output logic              user_irq_masked
);

  alu_op_e           op;
  logic              is_logic;
  logic [DATA_W-1:0] arith_res, logic_res, next_res;
  alu_flags_t        arith_flags, next_flags, flags_q;
  logic              logic_n, logic_z;
  logic [DATA_W-1:0] result_q;

  assign op       = alu_op_e'(op_code);
  assign is_logic = op_code[2];

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .opa       (opa),
    .opb       (opb),
    .op        (op),
    .byte_mode (byte_mode),
    .carry_in  (carry_in),
    .z_prev    (flags_q.z),
    .res       (arith_res),
    .flags     (arith_flags)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .opa       (opa),
    .opb       (opb),
    .op        (op),
    .byte_mode (byte_mode),
    .res       (logic_res),
    .n         (logic_n),
    .z         (logic_z)
  );

  always_comb begin
    next_res   = is_logic ? logic_res : arith_res;
    next_flags = arith_flags;
    if (is_logic) begin
      next_flags.n = logic_n;
      next_flags.z = logic_z;
    end
  end

  alu_stat_reg #(.IPL_W(IPL_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .upd_all     (op_valid && !is_logic),
    .upd_nz      (op_valid && is_logic),
    .flags_d     (next_flags),
    .ipl_wr_en   (ipl_wr_en),
    .ipl_wr_data (ipl_wr_data),
    .ipl_lock    (ipl_lock),
    .flags_q     (flags_q),
    .ipl_q       (ipl_field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (op_valid) begin
      result_q <= next_res;
    end
  end

  assign result          = result_q;
  assign flag_c          = flags_q.c;
  assign flag_dc         = flags_q.dc;
  assign flag_ov         = flags_q.ov;
  assign flag_n          = flags_q.n;
  assign flag_z          = flags_q.z;
  assign cpu_level       = {ipl_hi, ipl_field};
  assign user_irq_masked = ipl_hi || (&ipl_field);

endmodule

// File: rtl/alu_status_unit_chk.sv
module alu_status_unit_chk #(
  parameter int DATA_W = 16,
  parameter int IPL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              byte_mode,
  input logic              ipl_wr_en,
  input logic [IPL_W-1:0]  ipl_wr_data,
  input logic              ipl_lock,
  input logic [DATA_W-1:0] result,
  input logic              flag_c,
  input logic              flag_dc,
  input logic              flag_ov,
  input logic              flag_n,
  input logic              flag_z,
  input logic [IPL_W-1:0]  ipl_field
);

  localparam int HALF_W = DATA_W / 2;

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0) && !flag_c && !flag_dc && !flag_ov && !flag_n && !flag_z && (ipl_field == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result) && $stable({flag_c, flag_dc, flag_ov, flag_n, flag_z}));

  // R6
  chained_z_never_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 3'd1 || op_code == 3'd3) && !flag_z) |=> !flag_z);

  // R7
  logic_keeps_arith_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[2]) |=> $stable({flag_c, flag_dc, flag_ov}));

  // R8
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && byte_mode) |=> (result[DATA_W-1:HALF_W] == '0));

  // R10
  ipl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ipl_wr_en && !ipl_lock) |=> (ipl_field == $past(ipl_wr_data)));

  // R10
  ipl_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ipl_wr_en && !ipl_lock)) |=> $stable(ipl_field));

endmodule

bind alu_status_unit alu_status_unit_chk #(.DATA_W(DATA_W), .IPL_W(IPL_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .byte_mode   (byte_mode),
  .ipl_wr_en   (ipl_wr_en),
  .ipl_wr_data (ipl_wr_data),
  .ipl_lock    (ipl_lock),
  .result      (result),
  .flag_c      (flag_c),
  .flag_dc     (flag_dc),
  .flag_ov     (flag_ov),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .ipl_field   (ipl_field)
);

// File: tb/alu_status_unit_tb_top.sv
`timescale 1ns/1ps
module alu_status_unit_tb_top;

  localparam int DATA_W = 16;
  localparam int IPL_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [2:0]        op_code = '0;
  logic              byte_mode = 1'b0;
  logic [DATA_W-1:0] opa = '0, opb = '0;
  logic              carry_in = 1'b0;
  logic              ipl_wr_en = 1'b0;
  logic [IPL_W-1:0]  ipl_wr_data = '0;
  logic              ipl_lock = 1'b0;
  logic              ipl_hi = 1'b0;
  logic [DATA_W-1:0] result;
  logic              flag_c, flag_dc, flag_ov, flag_n, flag_z;
  logic [IPL_W-1:0]  ipl_field;
  logic [IPL_W:0]    cpu_level;
  logic              user_irq_masked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the status flags and result
  int mres = 0;
  bit mc = 0, mdc = 0, mov = 0, mn = 0, mz = 0;

  always #4 clk = ~clk;

  alu_status_unit #(.DATA_W(DATA_W), .IPL_W(IPL_W)) dut_i (
    .clk, .rst, .op_valid, .op_code, .byte_mode, .opa, .opb, .carry_in,
    .ipl_wr_en, .ipl_wr_data, .ipl_lock, .ipl_hi,
    .result, .flag_c, .flag_dc, .flag_ov, .flag_n, .flag_z,
    .ipl_field, .cpu_level, .user_irq_masked
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pack_state(input int r, input bit c, input bit dc, input bit ov, input bit n, input bit z);
    return (r & 32'hFFFF) | (int'(c) << 20) | (int'(dc) << 19) | (int'(ov) << 18) | (int'(n) << 17) | (int'(z) << 16);
  endfunction

  function automatic int dut_state();
    return pack_state(int'(result), flag_c, flag_dc, flag_ov, flag_n, flag_z);
  endfunction

  task automatic apply(input int op, input bit bm, input int a, input int b, input bit ci);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = op[2:0];
    byte_mode = bm;
    opa       = a[DATA_W-1:0];
    opb       = b[DATA_W-1:0];
    carry_in  = ci;
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  // arithmetic operation with model update (R1-R6, R8)
  task automatic do_arith(input int op, input bit bm, input int a, input int b, input bit ci, input string req);
    int w, mask, half, dm, aa, bb, tot, sa, sb, st, k;
    w    = bm ? 8 : 16;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    dm   = bm ? 15 : 255;
    aa   = a & mask;
    bb   = b & mask;
    sa   = (aa >= half) ? aa - (1 << w) : aa;
    sb   = (bb >= half) ? bb - (1 << w) : bb;
    if (op == 0 || op == 1) begin
      k   = (op == 1) ? int'(ci) : 0;
      tot = aa + bb + k;
      mc  = tot > mask;
      mdc = ((aa & dm) + (bb & dm) + k) > dm;
      st  = sa + sb + k;
    end else begin
      k   = (op == 3) ? int'(!ci) : 0;
      tot = aa - bb - k;
      mc  = aa >= bb + k;
      mdc = (aa & dm) >= (bb & dm) + k;
      st  = sa - sb - k;
    end
    mres = tot & mask;
    mov  = (st > half - 1) || (st < -half);
    mn   = ((mres >> (w - 1)) & 1) != 0;
    if (op == 1 || op == 3) mz = mz && (mres == 0);
    else                    mz = (mres == 0);
    apply(op, bm, a, b, ci);
    check(dut_state() == pack_state(mres, mc, mdc, mov, mn, mz), req, dut_state(),
          pack_state(mres, mc, mdc, mov, mn, mz));
  endtask

  // logic operation with model update (R5, R7, R8)
  task automatic do_logic(input int op, input bit bm, input int a, input int b, input string req);
    int w, mask, r;
    w    = bm ? 8 : 16;
    mask = (1 << w) - 1;
    case (op)
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      default: r = a;
    endcase
    mres = r & mask;
    mn   = ((mres >> (w - 1)) & 1) != 0;
    mz   = (mres == 0);
    apply(op, bm, a, b, 1'b0);
    check(dut_state() == pack_state(mres, mc, mdc, mov, mn, mz), req, dut_state(),
          pack_state(mres, mc, mdc, mov, mn, mz));
  endtask

  function automatic int corner(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h00FF;
      6: return 16'h0F0F;
      default: return 16'h8001;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check(dut_state() == 0, "R12 reset flags/result", dut_state(), 0);
    check(ipl_field == 0 && cpu_level == 0 && !user_irq_masked, "R12 reset ipl",
          int'(cpu_level), 0);

    // byte-mode grid over the arithmetic operations (R1-R5, R8)
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 7)
          do_arith(op, 1'b1, a | 16'hA500, b | 16'h5A00, ((a + b) & 1) != 0, "R1 R2 R3 R4 R5 R8 byte arith");

    // word-mode corner operands (R1-R5)
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int ci = 0; ci < 2; ci++)
            do_arith(op, 1'b0, corner(i), corner(j), ci != 0, "R1 R2 R3 R4 R5 word corner");

    // word-mode pseudo-random operands, logic ops interleaved (R1-R5, R7)
    lf = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      int a, b;
      lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
      a  = (lf >> 8) & 16'hFFFF;
      lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
      b  = (lf >> 8) & 16'hFFFF;
      do_arith(i % 4, 1'b0, a, b, (lf & 1) != 0, "R1 R2 R3 R4 R5 word random");
      do_logic(4 + (i % 4), (i % 3) == 0, b, a, "R5 R7 R8 logic");
    end

    // R6: chained operations never set zero
    do_arith(0, 1'b0, 0, 0, 1'b0, "R6 plain add sets z");
    do_arith(1, 1'b0, 0, 0, 1'b0, "R6 chained zero keeps z=1");
    do_arith(1, 1'b0, 1, 0, 1'b0, "R6 chained nonzero clears z");
    do_arith(1, 1'b0, 0, 0, 1'b0, "R6 chained zero keeps z=0");
    do_arith(3, 1'b0, 5, 5, 1'b1, "R6 chained sub zero keeps z=0");
    do_arith(2, 1'b1, 9, 9, 1'b0, "R6 plain sub sets z");
    do_arith(3, 1'b1, 9, 9, 1'b1, "R6 chained sub zero keeps z=1");

    // R7: logic op after an arithmetic op that set c, dc and ov
    do_arith(0, 1'b0, 16'h8888, 16'h8888, 1'b0, "R7 setup");
    do_logic(6, 1'b0, 16'h1234, 16'h1234, "R7 xor keeps c dc ov");

    // R9: idle cycles with changing inputs
    @(negedge clk);
    opa = 16'hFFFF; opb = 16'h0001; op_code = 3'd0; byte_mode = 1'b0; carry_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(dut_state() == pack_state(mres, mc, mdc, mov, mn, mz), "R9 hold when idle",
          dut_state(), pack_state(mres, mc, mdc, mov, mn, mz));

    // R10, R11: priority field and level
    for (int h = 0; h < 2; h++)
      for (int f = 0; f < 8; f++) begin
        @(negedge clk);
        ipl_hi = h[0]; ipl_lock = 1'b0; ipl_wr_en = 1'b1; ipl_wr_data = f[2:0];
        @(negedge clk);
        ipl_wr_en = 1'b0;
        check(int'(ipl_field) == f, "R10 field write", int'(ipl_field), f);
        check(int'(cpu_level) == h * 8 + f, "R11 level", int'(cpu_level), h * 8 + f);
        check(user_irq_masked == (h == 1 || f == 7), "R11 masking", int'(user_irq_masked),
              int'(h == 1 || f == 7));
        ipl_lock = 1'b1; ipl_wr_en = 1'b1; ipl_wr_data = ~f[2:0];
        @(negedge clk);
        ipl_wr_en = 1'b0; ipl_lock = 1'b0;
        check(int'(ipl_field) == f, "R10 locked write ignored", int'(ipl_field), f);
      end

    // R12: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(dut_state() == 0 && ipl_field == 0, "R12 reset clears", dut_state(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule